// File: doc/BRIEF.md
# Shared Bidirectional I/O Byte

This block is one 8-bit buffered register that two parties share. A processor reaches it through a byte select and a field specification. An external user reaches it through an 8-bit data path with an output enable and two active-low controls. On the processor side a field read is combinational. It returns the chosen bits right-justified with zeros above them. A field write is synchronous and changes only the chosen bits. On the user side the two controls pick one of three modes, independent of the processor: float, drive, or capture. The user side always wins a conflict, so user input is never lost.

The mode is an enumerated value decoded from the two controls with a unique case. FLOAT means both controls are high. DRIVE means the output control is low and the input control is high. CAPTURE means the input control is low, whatever the output control is. The decode holds no state, so the transitions follow the controls directly. Any control change moves to the mode it names on the same cycle. The only state is the stored byte. It leaves reset at all ones, so that downstream outputs stay inactive during start-up.

Bit numbering follows the processor's convention: position 0 is the most significant bit (`usr_dout[7]`) and position 7 is the least significant bit (`usr_dout[0]`). A field is named by its right-most position `cpu_pos` and its length `cpu_len`. It covers positions `cpu_pos-cpu_len+1` through `cpu_pos`. The right-most position maps to bit 0 of `cpu_rdata`/`cpu_wdata`.

Top module: `iob_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, the stored byte is 8'hFF until it is written.
- R2: In FLOAT (both `usr_in_n` and `usr_out_n` high), `usr_oe` is 0 and `usr_dout` is 0.
- R3: In DRIVE (`usr_out_n` low, `usr_in_n` high), `usr_oe` is 1 and `usr_dout` equals the stored byte in the same cycle.
- R4: In CAPTURE (`usr_in_n` low, `usr_out_n` either value), `usr_oe` is 0 and the rising clock edge loads `usr_din` into the stored byte.
- R5: Capture and drive work whether `cpu_sel` is high or low.
- R6: If a capture and a processor write (`cpu_sel` and `cpu_we` high) occur in the same cycle, the stored byte becomes `usr_din` and the processor write is discarded.
- R7: With `cpu_sel` high, `cpu_rdata` holds the field's bits right-justified and zero-filled. Position p maps to stored bit 7-p, so position 0 is the MSB.
- R8: A processor write with `cpu_sel` and `cpu_we` high (and no capture) replaces only the field's bits with the low bits of `cpu_wdata`. All other bits are unchanged.
- R9: `cpu_len` of 0 is an empty field: reads give 0 and writes change nothing. A length above 8 acts as 8. Field bits that would fall beyond position 0 are dropped.
- R10: With `cpu_sel` low, `cpu_rdata` is 0 and `cpu_we` has no effect on the stored byte.
- R11: A byte captured at an edge appears on `cpu_rdata` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; captures and writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to all ones |
| cpu_sel | input | 1 | Processor byte select |
| cpu_we | input | 1 | Processor field write strobe |
| cpu_pos | input | 3 | Right-most position of the field (0 = MSB) |
| cpu_len | input | 4 | Field length, 0 to 8 (larger values act as 8) |
| cpu_wdata | input | 8 | Right-justified write field |
| cpu_rdata | output | 8 | Right-justified, zero-filled read field |
| usr_in_n | input | 1 | Active-low user input (capture) control |
| usr_out_n | input | 1 | Active-low user output (drive) control |
| usr_din | input | 8 | User data into the byte |
| usr_dout | output | 8 | Stored byte toward the user, 0 when not driving |
| usr_oe | output | 1 | Tri-state enable for the user data lines |

## Verification
On every cycle, the assertions check the mode outputs against the two controls: float, and drive of the stored byte. They also check that a capture lands on the next edge and that the user wins over a simultaneous processor write. They check that the byte holds when nobody writes it, and that a deselected read returns zero. Only the bench's scenarios can show the field arithmetic: which bits a write touches, how reads are justified under the MSB-first numbering, and how empty, oversize and clipped fields behave. The same holds for the reset value and for read-back of a capture in the next cycle.

// File: rtl/iob_pkg.sv
package iob_pkg;
    typedef enum logic [1:0] {
        MODE_FLOAT   = 2'd0,
        MODE_DRIVE   = 2'd1,
        MODE_CAPTURE = 2'd2
    } iob_mode_e;
endpackage

// File: rtl/iob_field.sv
module iob_field #(
    parameter int W     = 8,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = $clog2(W) + 1
) (
    input  logic [W-1:0]     stored,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rd_val,
    output logic [W-1:0]     wr_val
);
    localparam int TOP = W - 1;

    logic [W-1:0]     len_mask;
    logic [W-1:0]     place_mask;
    logic [POS_W-1:0] offset;

    // Length mask: bit i is set when the field is longer than i.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign len_mask[i] = (len > LEN_W'(i));
    end

    // Position p lives at stored index TOP-p.
    assign offset     = POS_W'(TOP) - pos;
    assign place_mask = len_mask << offset;
    assign rd_val     = (stored >> offset) & len_mask;
    assign wr_val     = (stored & ~place_mask) | ((wdata << offset) & place_mask);
endmodule

// File: rtl/iob_ctrl.sv
module iob_ctrl
    import iob_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         in_n,
    input  logic         out_n,
    input  logic [W-1:0] stored,
    output iob_mode_e    mode,
    output logic         oe,
    output logic [W-1:0] dout
);
    // Mode decode from the user controls.
    always_comb begin
        unique case ({in_n, out_n})
            2'b11:   mode = MODE_FLOAT;
            2'b10:   mode = MODE_DRIVE;
            default: mode = MODE_CAPTURE;
        endcase
    end

    // Outputs per mode.
    always_comb begin
        unique case (mode)
            MODE_DRIVE: begin
                oe   = 1'b1;
                dout = stored;
            end
            default: begin
                oe   = 1'b0;
                dout = '0;
            end
        endcase
    end
endmodule

// File: rtl/iob_port.sv
module iob_port
    import iob_pkg::*;
#(
    parameter int W     = 8,
    parameter int POS_W = $clog2(W),
    parameter int LEN_W = $clog2(W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_sel,
    input  logic             cpu_we,
    input  logic [POS_W-1:0] cpu_pos,
    input  logic [LEN_W-1:0] cpu_len,
    input  logic [W-1:0]     cpu_wdata,
    output logic [W-1:0]     cpu_rdata,
    input  logic             usr_in_n,
    input  logic             usr_out_n,
    input  logic [W-1:0]     usr_din,
    output logic [W-1:0]     usr_dout,
    output logic             usr_oe
);
    logic [W-1:0] stored_q;
    logic [W-1:0] field_rd;
    logic [W-1:0] field_wr;
    iob_mode_e    mode;
    logic         cpu_write;

    iob_ctrl #(.W(W)) u_ctrl (
        .in_n   (usr_in_n),
        .out_n  (usr_out_n),
        .stored (stored_q),
        .mode   (mode),
        .oe     (usr_oe),
        .dout   (usr_dout)
    );

    iob_field #(.W(W), .POS_W(POS_W), .LEN_W(LEN_W)) u_field (
        .stored (stored_q),
        .pos    (cpu_pos),
        .len    (cpu_len),
        .wdata  (cpu_wdata),
        .rd_val (field_rd),
        .wr_val (field_wr)
    );

    assign cpu_write = cpu_sel && cpu_we;
    assign cpu_rdata = cpu_sel ? field_rd : '0;

    // Storage: user capture has priority over the processor write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '1;
        end else if (mode == MODE_CAPTURE) begin
            stored_q <= usr_din;
        end else if (cpu_write) begin
            stored_q <= field_wr;
        end
    end

    a_r2_float: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_in_n && usr_out_n) |-> (!usr_oe && usr_dout == '0));

    a_r3_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_in_n && !usr_out_n) |-> (usr_oe && usr_dout == stored_q));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_in_n |=> (stored_q == $past(usr_din)));

    a_r6_user_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!usr_in_n && cpu_sel && cpu_we) |=> (stored_q == $past(usr_din)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_in_n && !(cpu_sel && cpu_we)) |=> $stable(stored_q));

    a_r10_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_sel |-> (cpu_rdata == '0));
endmodule

// File: tb/iob_port_test.sv
module iob_port_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        string      tag;
        logic [16:0] exp;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [2:0] cpu_pos = '0;
    logic [3:0] cpu_len = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       usr_in_n = 1'b1, usr_out_n = 1'b1;
    logic [7:0] usr_din = '0, usr_dout;
    logic       usr_oe;

    int errors = 0;
    int checks = 0;
    logic [7:0] model = 8'hFF;
    sb_item_t sbq[$];

    iob_port uut (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
        .cpu_pos(cpu_pos), .cpu_len(cpu_len), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .usr_in_n(usr_in_n), .usr_out_n(usr_out_n),
        .usr_din(usr_din), .usr_dout(usr_dout), .usr_oe(usr_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference field read, walking positions (0 = MSB).
    function automatic logic [7:0] ref_rd(logic [7:0] b, int pos, int len);
        logic [7:0] r = '0;
        int l = (len > 8) ? 8 : len;
        for (int k = 0; k < l; k++) begin
            if (pos - k >= 0) r[k] = b[7 - (pos - k)];
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_wr(logic [7:0] b, int pos, int len, logic [7:0] wd);
        logic [7:0] r = b;
        int l = (len > 8) ? 8 : len;
        for (int k = 0; k < l; k++) begin
            if (pos - k >= 0) r[7 - (pos - k)] = wd[k];
        end
        return r;
    endfunction

    // Monitor: pops expected items and compares against the ports.
    initial begin
        sb_item_t it;
        logic [16:0] act;
        forever begin
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            act = {usr_oe, usr_dout, cpu_rdata};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual oe=%b dout=%h rdata=%h expected oe=%b dout=%h rdata=%h",
                         it.tag, act[16], act[15:8], act[7:0],
                         it.exp[16], it.exp[15:8], it.exp[7:0]);
            end
        end
    end

    // Driver: applies one cycle of stimulus, queues the expected outputs, updates the model.
    task automatic step(string tag, logic in_n, logic out_n, logic [7:0] din,
                        logic sel, logic we, int pos, int len, logic [7:0] wd);
        sb_item_t it;
        logic oe;
        @(negedge clk);
        usr_in_n = in_n; usr_out_n = out_n; usr_din = din;
        cpu_sel = sel; cpu_we = we; cpu_pos = 3'(pos); cpu_len = 4'(len); cpu_wdata = wd;
        #1;
        oe = in_n && !out_n;
        it.tag = tag;
        it.exp = {oe, oe ? model : 8'h00, sel ? ref_rd(model, pos, len) : 8'h00};
        sbq.push_back(it);
        @(posedge clk);
        if (!in_n) model = din;
        else if (sel && we) model = ref_wr(model, pos, len, wd);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset value observed while still in reset
        @(negedge clk);
        cpu_sel = 1'b1; cpu_pos = 3'd7; cpu_len = 4'd8; #1;
        checks++;
        if (cpu_rdata !== 8'hFF) begin
            errors++;
            $display("FAIL R1 in reset: actual %h expected ff", cpu_rdata);
        end
        rst_n = 1'b1;
        step("R2 float, R10 deselected read", 1, 1, 8'h00, 0, 0, 7, 8, 8'h00);
        step("R1 reset value after release", 1, 1, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R3 drive", 1, 0, 8'h00, 0, 0, 7, 8, 8'h00);
        step("R5 capture while deselected", 0, 1, 8'hA5, 0, 0, 7, 8, 8'h00);
        step("R11 capture read back", 1, 0, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R4 capture with both controls low", 0, 0, 8'h3C, 1, 0, 7, 8, 8'h00);
        step("R11 second capture read back", 1, 1, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R8 field write pos4 len3", 1, 1, 8'h00, 1, 1, 4, 3, 8'hFD);
        step("R8 full byte after field write", 1, 0, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R7 read field pos4 len3", 1, 1, 8'h00, 1, 0, 4, 3, 8'h00);
        step("R7 read MSB pos0 len1", 1, 1, 8'h00, 1, 0, 0, 1, 8'h00);
        step("R7 read pos5 len2", 1, 1, 8'h00, 1, 0, 5, 2, 8'h00);
        step("R10 write while deselected", 1, 1, 8'h00, 0, 1, 7, 8, 8'h00);
        step("R10 byte unchanged", 1, 1, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R6 simultaneous write", 0, 1, 8'h81, 1, 1, 7, 8, 8'h7E);
        step("R6 user data kept", 1, 0, 8'h00, 1, 0, 7, 8, 8'h00);
        step("R9 zero length write", 1, 1, 8'h00, 1, 1, 3, 0, 8'hFF);
        step("R9 zero length read", 1, 1, 8'h00, 1, 0, 3, 0, 8'h00);
        step("R9 oversize length write", 1, 1, 8'h00, 1, 1, 7, 12, 8'h5A);
        step("R9 oversize read", 1, 1, 8'h00, 1, 0, 7, 15, 8'h00);
        step("R9 clipped write pos1 len5", 1, 1, 8'h00, 1, 1, 1, 5, 8'h1F);
        step("R9 clipped read pos1 len5", 1, 0, 8'h00, 1, 0, 1, 5, 8'h00);
        step("R8 LSB write pos7 len1", 1, 1, 8'h00, 1, 1, 7, 1, 8'h00);
        step("R8 full byte after LSB write", 1, 0, 8'h00, 1, 0, 7, 8, 8'h00);
        // R1: second reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        model = 8'hFF;
        @(negedge clk);
        rst_n = 1'b1;
        step("R1 value after second reset", 1, 0, 8'h00, 1, 0, 7, 8, 8'h00);
        @(negedge clk);
        wait (sbq.size() == 0);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule